// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets synchronous logic reach an external asynchronous static RAM of 512K bytes. A client issues one byte read or one byte write at a time on a valid/ready handshake. The controller then drives the memory's three active-low strobes (chip select, output enable, write strobe), a 19-bit address and a byte-wide data bus. The data bus is split into an output value, an input value and a drive enable. It holds each phase for as many clocks as the memory's timing minimums require at the configured clock period, and reports completion with a one-cycle done pulse that carries the read byte.

Each timing minimum is given as a nanosecond parameter: read access, write strobe width, data setup, full write cycle and bus release time. It is converted to a whole number of clocks when the design is elaborated. A write raises the output enable first and puts the address and data on the pins. It then pulls chip select and write strobe low together and ends the write on the rising write strobe, while address and data stay on the pins for one more cycle. A read is followed by a release gap with every strobe high, so that the memory has let go of the bus before the controller can drive it again.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and in the first cycle after it, memCeN, memOeN and memWeN are 1, memDataOe and rspDone are 0, and reqReady is 1.
- R2: A request is taken only on a clock edge where reqValid and reqReady are both 1. reqReady is 0 from the edge that takes a request until the transaction has finished, and reqValid has no effect in that time.
- R3: A read (reqWrite=0) holds memCeN=0, memOeN=0 and memWeN=1 with memAddr equal to the requested address for exactly ACC cycles. The byte on memDataIn at the end of the last of those cycles is returned on rspRdata while rspDone is 1.
- R4: For a read, rspDone is 1 for exactly one cycle, and that cycle is the ACC+1-th cycle after the accepting edge.
- R5: A write (reqWrite=1) spends one setup cycle with all strobes high and the address and data on the pins. It then spends PULSE cycles with memCeN=0 and memWeN=0, then one hold cycle with memWeN=1 and memCeN=0. rspDone is 1 for the one cycle after the hold cycle, and reqReady is 1 in that same cycle.
- R6: memOeN stays 1 throughout a write. memDataOe is 1 only in the setup, strobe and hold cycles of a write, and is never 1 while memOeN is 0.
- R7: After a read, all strobes are high for TURN cycles, counting the done cycle, before reqReady returns to 1.
- R8: memAddr does not change while memCeN stays 0, and memDataOut does not change while memWeN stays 0.
- R9: Each phase count is the ceiling of its time minimum over CLK_PERIOD_NS, with a floor of one. PULSE is the largest of the strobe-width count, the data-setup count and the write-cycle count less two.
- R10: Between transactions memCeN is 1, memWeN is 1 and memOeN is 1.
- R11: A read returns the byte last written to the same address. Writes to other addresses leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqWdata | input | DATA_W | Byte to write |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | DATA_W | Byte read, valid while rspDone is 1 after a read |
| memAddr | output | ADDR_W | Memory address pins |
| memDataOut | output | DATA_W | Value the controller puts on the data bus |
| memDataIn | input | DATA_W | Value the memory puts on the data bus |
| memDataOe | output | 1 | Controller drives the data bus when 1 |
| memCeN | output | 1 | Active-low chip select |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write strobe |

## Verification
The assertions assume a client that presents reqWrite, reqAddr and reqWdata together with reqValid and only needs them to be valid on the accepting edge. They also assume a memory that returns stable read data once the access time has elapsed. The bench drives requests half a cycle away from the clock and lowers reqValid right after acceptance, except when it deliberately raises a stray request during a busy read to show that it is ignored. The memory model writes on the rising write strobe and updates its read output at falling clock edges. Random traffic draws addresses from a small pool that includes both ends of the address range, so that reads meet earlier writes.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_REL,
    ST_WR_SET,
    ST_WR_PULSE,
    ST_WR_HOLD
  } state_t;

  // Control to datapath: next pin levels plus one-shot actions
  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic drive;
    logic done;
    logic latch;
    logic capture;
  } strobe_t;

  function automatic int unsigned nsToCycles(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ACC_C   = 1,
  parameter int unsigned PULSE_C = 1,
  parameter int unsigned TURN_C  = 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t stb
);

  localparam int unsigned MAX_C = maxOf(maxOf(ACC_C, PULSE_C), TURN_C);
  localparam int unsigned CNT_W = (MAX_C < 2) ? 1 : $clog2(MAX_C);

  localparam logic [CNT_W-1:0] ACC_LD   = CNT_W'(ACC_C - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_C - 1);
  localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_C - 1);

  state_t           stateQ, stateNext;
  logic [CNT_W-1:0] cntQ, cntNext;
  logic             cntZero;

  assign cntZero  = (cntQ == '0);
  assign reqReady = (stateQ == ST_IDLE);

  always_comb begin
    stateNext   = stateQ;
    cntNext     = cntQ;
    stb.latch   = 1'b0;
    stb.capture = 1'b0;
    stb.done    = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          stb.latch = 1'b1;
          if (reqWrite) begin
            stateNext = ST_WR_SET;
          end else begin
            stateNext = ST_RD_ACC;
            cntNext   = ACC_LD;
          end
        end
      end
      ST_RD_ACC: begin
        if (cntZero) begin
          stb.capture = 1'b1;
          stb.done    = 1'b1;
          stateNext   = ST_RD_REL;
          cntNext     = TURN_LD;
        end else begin
          cntNext = cntQ - 1'b1;
        end
      end
      ST_RD_REL: begin
        if (cntZero) stateNext = ST_IDLE;
        else         cntNext   = cntQ - 1'b1;
      end
      ST_WR_SET: begin
        stateNext = ST_WR_PULSE;
        cntNext   = PULSE_LD;
      end
      ST_WR_PULSE: begin
        if (cntZero) stateNext = ST_WR_HOLD;
        else         cntNext   = cntQ - 1'b1;
      end
      ST_WR_HOLD: begin
        stb.done  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // Pin levels for the next cycle follow the next state
  always_comb begin
    stb.ceN   = !(stateNext == ST_RD_ACC || stateNext == ST_WR_PULSE || stateNext == ST_WR_HOLD);
    stb.oeN   = (stateNext != ST_RD_ACC);
    stb.weN   = (stateNext != ST_WR_PULSE);
    stb.drive = (stateNext == ST_WR_SET || stateNext == ST_WR_PULSE || stateNext == ST_WR_HOLD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateNext;
      cntQ   <= cntNext;
    end
  end

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqReady && reqValid) |=> !reqReady);

  // R5
  set_then_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_WR_SET) |=> (stateQ == ST_WR_PULSE));

  // R3
  capture_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.capture |-> (stateQ == ST_RD_ACC));

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PULSE_C = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata
);

  localparam int unsigned WCNT_W = $clog2(PULSE_C + 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      memCeN    <= 1'b1;
      memOeN    <= 1'b1;
      memWeN    <= 1'b1;
      memDataOe <= 1'b0;
      rspDone   <= 1'b0;
    end else begin
      memCeN    <= stb.ceN;
      memOeN    <= stb.oeN;
      memWeN    <= stb.weN;
      memDataOe <= stb.drive;
      rspDone   <= stb.done;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      memAddr    <= '0;
      memDataOut <= '0;
      rspRdata   <= '0;
    end else begin
      if (stb.latch) memAddr <= reqAddr;
      if (stb.latch && reqWrite) memDataOut <= reqWdata;
      if (stb.capture) rspRdata <= memDataIn;
    end
  end

  // Width of the current write strobe, saturating
  logic [WCNT_W-1:0] weLowCnt;
  always_ff @(posedge clk) begin
    if (!rst_n) weLowCnt <= '0;
    else if (memWeN) weLowCnt <= '0;
    else if (weLowCnt != {WCNT_W{1'b1}}) weLowCnt <= weLowCnt + 1'b1;
  end

  // R6
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memDataOe |-> memOeN);

  // R6
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !memWeN |-> (memOeN && !memCeN && memDataOe));

  // R8
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  // R8
  wdata_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!memWeN && $past(!memWeN)) |-> $stable(memDataOut));

  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(memWeN) && $past(rst_n)) |-> (weLowCnt >= WCNT_W'(PULSE_C)));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rspDone |=> !rspDone);

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned T_ACCESS_NS   = 12,
  parameter int unsigned T_WPULSE_NS   = 8,
  parameter int unsigned T_DSETUP_NS   = 6,
  parameter int unsigned T_WCYCLE_NS   = 12,
  parameter int unsigned T_TURN_NS     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  input  logic [DATA_W-1:0] memDataIn,
  output logic              memDataOe,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN
);

  localparam int unsigned ACC_C  = nsToCycles(T_ACCESS_NS, CLK_PERIOD_NS);
  localparam int unsigned WP_C   = nsToCycles(T_WPULSE_NS, CLK_PERIOD_NS);
  localparam int unsigned DS_C   = nsToCycles(T_DSETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned WC_C   = nsToCycles(T_WCYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned WC_P   = (WC_C > 3) ? WC_C - 2 : 1;
  localparam int unsigned PULSE_C = maxOf(maxOf(WP_C, DS_C), WC_P);
  localparam int unsigned TURN_C = nsToCycles(T_TURN_NS, CLK_PERIOD_NS);

  strobe_t stb;

  sram_ctl_fsm #(
    .ACC_C  (ACC_C),
    .PULSE_C(PULSE_C),
    .TURN_C (TURN_C)
  ) fsm_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .stb     (stb)
  );

  sram_ctl_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PULSE_C(PULSE_C)
  ) dpath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .reqWrite  (reqWrite),
    .memDataIn (memDataIn),
    .memAddr   (memAddr),
    .memDataOut(memDataOut),
    .memDataOe (memDataOe),
    .memCeN    (memCeN),
    .memOeN    (memOeN),
    .memWeN    (memWeN),
    .rspDone   (rspDone),
    .rspRdata  (rspRdata)
  );

  // R10
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> (memCeN && memOeN && memWeN && !memDataOe));

endmodule

// File: tb/sram_ctl_tb_top.sv
module sram_ctl_tb_top;

  localparam int unsigned PER    = 20;
  localparam int unsigned T_ACC  = 45;
  localparam int unsigned T_WP   = 30;
  localparam int unsigned T_DS   = 50;
  localparam int unsigned T_WC   = 12;
  localparam int unsigned T_TURN = 25;

  function automatic int unsigned cyc(input int unsigned ns);
    int unsigned c;
    c = (ns + PER - 1) / PER;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned expPulse();
    int unsigned m;
    int unsigned wc;
    m = cyc(T_WP);
    if (cyc(T_DS) > m) m = cyc(T_DS);
    wc = (cyc(T_WC) > 3) ? cyc(T_WC) - 2 : 1;
    if (wc > m) m = wc;
    return m;
  endfunction

  // R9: expected phase counts computed from the rule
  localparam int unsigned E_ACC   = (T_ACC + PER - 1) / PER;
  localparam int unsigned E_TURN  = (T_TURN + PER - 1) / PER;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        rspDone;
  logic [7:0]  rspRdata;
  logic [18:0] memAddr;
  logic [7:0]  memDataOut;
  logic [7:0]  memDataIn = 8'h00;
  logic        memDataOe;
  logic        memCeN, memOeN, memWeN;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sram_ctl #(
    .CLK_PERIOD_NS(PER),
    .T_ACCESS_NS  (T_ACC),
    .T_WPULSE_NS  (T_WP),
    .T_DSETUP_NS  (T_DS),
    .T_WCYCLE_NS  (T_WC),
    .T_TURN_NS    (T_TURN)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspRdata(rspRdata), .memAddr(memAddr),
    .memDataOut(memDataOut), .memDataIn(memDataIn), .memDataOe(memDataOe),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural memory
  logic [7:0] memModel [int];
  logic [7:0] refMem   [int];
  int weLow = 0;
  int monBad = 0;

  function automatic logic [7:0] refGet(input logic [18:0] a);
    return refMem.exists(int'(a)) ? refMem[int'(a)] : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (!memCeN && !memOeN && memWeN)
      memDataIn <= memModel.exists(int'(memAddr)) ? memModel[int'(memAddr)] : 8'h00;
    else
      memDataIn <= 8'hA5;
    if (!memWeN) weLow++;
    // R6: contention, or output enable low while writing
    if (rst_n && memDataOe && !memOeN) monBad++;
    if (rst_n && !memWeN && !memOeN) monBad++;
  end

  always @(posedge memWeN) begin
    if (memCeN === 1'b0) begin
      memModel[int'(memAddr)] = memDataOut;
      // R5: strobe width seen by the memory
      check(weLow == expPulse(), "R5 we width", weLow, expPulse());
    end
    weLow = 0;
  end

  task automatic doWrite(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqWdata = ~d;
    // setup cycle
    check(memCeN && memWeN && memOeN && memDataOe && memAddr == a && memDataOut == d,
          "R5 setup", {memCeN, memWeN, memOeN, memDataOe}, 4'b1111);
    check(!reqReady, "R2 busy", reqReady, 0);
    for (int i = 0; i < int'(expPulse()); i++) begin
      @(negedge clk);
      check(!memCeN && !memWeN && memOeN && memAddr == a && memDataOut == d,
            "R5 pulse", {memCeN, memWeN, memOeN}, 3'b001);
    end
    @(negedge clk);
    check(!memCeN && memWeN && memDataOe && memAddr == a && memDataOut == d && !rspDone,
          "R5 hold", {memCeN, memWeN, memDataOe}, 3'b011);
    @(negedge clk);
    check(rspDone && reqReady && memCeN && !memDataOe, "R5 done",
          {rspDone, reqReady, memCeN, memDataOe}, 4'b1110);
    refMem[int'(a)] = d;
  endtask

  task automatic doRead(input logic [18:0] a, input bit stray);
    logic [7:0] e;
    e = refGet(a);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a;
    if (stray) begin
      // R2: a request raised while busy is ignored
      reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = ~e;
    end
    for (int i = 0; i < int'(E_ACC); i++) begin
      if (i > 0) @(negedge clk);
      if (i == 1) reqValid = 1'b0;
      check(!memCeN && !memOeN && memWeN && !memDataOe && memAddr == a && !rspDone,
            "R3 access", {memCeN, memOeN, memWeN}, 3'b001);
      check(!reqReady, "R2 busy read", reqReady, 0);
    end
    reqValid = 1'b0;
    @(negedge clk);
    // R4: done in the ACC+1-th cycle; R11 data
    check(rspDone, "R4 done timing", rspDone, 1);
    check(rspRdata == e, "R11 read data", rspRdata, e);
    for (int i = 0; i < int'(E_TURN); i++) begin
      if (i > 0) begin
        @(negedge clk);
        check(!rspDone, "R4 single pulse", rspDone, 0);
      end
      check(!reqReady && memCeN && memOeN && memWeN && !memDataOe, "R7 release",
            {reqReady, memCeN, memOeN, memWeN}, 4'b0111);
    end
    @(negedge clk);
    check(reqReady, "R7 ready after release", reqReady, 1);
    check(memCeN && memOeN && memWeN, "R10 standby", {memCeN, memOeN, memWeN}, 3'b111);
  endtask

  logic [18:0] pool [16];

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1
    check(memCeN && memOeN && memWeN && !memDataOe && !rspDone && reqReady, "R1 reset",
          {memCeN, memOeN, memWeN, memDataOe, rspDone, reqReady}, 6'b111001);
    rst_n = 1'b1;
    @(negedge clk);
    check(memCeN && memOeN && memWeN && !memDataOe && !rspDone && reqReady, "R1 after reset",
          {memCeN, memOeN, memWeN, memDataOe, rspDone, reqReady}, 6'b111001);
    // R9: the bench's own cycle counts are not degenerate
    check(E_ACC == 3 && expPulse() == 3 && E_TURN == 2, "R9 counts",
          int'(E_ACC * 100 + expPulse() * 10 + E_TURN), 332);

    pool[0] = 19'h00000;
    pool[1] = 19'h7FFFF;
    for (int i = 2; i < 16; i++) pool[i] = 19'($urandom);

    // Directed corners
    doWrite(19'h00000, 8'hFF);
    doWrite(19'h7FFFF, 8'h00);
    doRead(19'h00000, 1'b0);
    doRead(19'h7FFFF, 1'b0);
    doWrite(19'h7FFFF, 8'h5A);
    doRead(19'h7FFFF, 1'b0);
    doRead(19'h00000, 1'b1);
    doRead(19'h00000, 1'b0);
    doRead(pool[5], 1'b0);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic [18:0] a;
      a = pool[$urandom % 16];
      if ($urandom % 2) doWrite(a, 8'($urandom));
      else doRead(a, ($urandom % 8) == 0);
      if ($urandom % 3 == 0) repeat ($urandom % 3) @(negedge clk);
    end

    check(monBad == 0, "R6 bus monitor", monBad, 0);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule